// File: doc/BRIEF.md
# Coupling-Fault-Injecting Dual-Port Memory

This block is a two-port register-array memory with the port interface of an ordinary synchronous RAM. It is used as a stand-in for a real array when a built-in self-test engine is verified. One victim bit can be made to misbehave according to the state of, or the accesses to, a single aggressor bit in a neighbouring word. Both ports can read or write any word in every cycle. Reads return data one cycle later, and a read returns the content stored before any write in the same cycle.

The words are laid out as a physical grid with a parameterised number of words per row. The victim word and bit are fixed by parameter. The aggressor is the same bit position in one of the victim's four grid neighbours. That neighbour is named by a 2-bit parameter or is derived from a seed. Run-time inputs enable the fault, pick the coupling kind, and set the aggressor and victim levels that arm it.

Top module: `cfi_dpmem`

## Requirements
- R1: After reset every word holds zero and both read outputs are zero.
- R2: A read on either port (`en`=1, `we`=0) returns its word one cycle later. A read and a write to the same word in one cycle return the old content. A written word reads back with the written value.
- R3: When both ports write the same word in one cycle, port A's data is stored.
- R4: Word `w` lies in row `w / WORDS_PER_ROW` and column `w % WORDS_PER_ROW`. The neighbour index means 0 above, 1 below, 2 left and 3 right. A neighbour that would fall off the grid is replaced by the opposite one. In random mode the index is `(SEED ^ SEED>>3 ^ SEED>>7) & 3`. The fault acts on bit `VICTIM_BIT` of the victim word and on the same bit of the aggressor word.
- R5: With `fault_en`=0, or with `fault_kind`=7, the memory behaves ideally.
- R6: Kind 0 (state): after any cycle in which the aggressor bit equals `agg_level` and the victim bit equals `vic_level`, the victim bit is set to the inverse of `vic_level`.
- R7: Kind 1 (disturb): any read or write on the aggressor word, by either port, inverts the victim bit. The inversion applies on top of any write to the victim in the same cycle.
- R8: Kind 2 (transition): while armed, a write that would move the victim bit away from `vic_level` leaves that bit unchanged. The other bits are still written.
- R9: Kind 3 (incorrect read): while armed, a read of the victim returns the victim bit inverted, and the cell is not changed.
- R10: Kind 4 (read destructive): while armed, a read of the victim inverts the cell bit and returns the inverted value.
- R11: Kind 5 (deceptive read destructive): while armed, a read of the victim returns the correct value but inverts the cell bit.
- R12: Kind 6 (random read): while armed, a read of the victim returns a pseudo-random value in the victim bit. The other bits are correct and the cell is not changed.
- R13: "Armed" for kinds 2 to 6 means `fault_en`=1 and the stored aggressor bit equal to `agg_level` at the start of the cycle, before that cycle's writes. A destructive read does not change the cell if the victim is written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, one cycle after the read |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, one cycle after the read |
| fault_en | input | 1 | Enables the injected coupling fault |
| fault_kind | input | 3 | Coupling kind, 0 to 6 as in R6 to R12; 7 means none |
| agg_level | input | 1 | Aggressor bit level that arms the fault |
| vic_level | input | 1 | Victim bit level used by the state and transition kinds |

## Verification
Read data is due one cycle after the read request. The bench drives each request after a falling edge and compares the output at the next falling edge, after the single capturing edge. A cell corruption (state enforcement, disturb, destructive read or blocked transition) is stored at the same edge as the access that causes it. It is therefore visible only to a read issued in the following cycle, whose result appears one cycle after that. The bench keeps a shadow array that it updates exactly once per clock edge, so each read is compared against the stored state at the start of its own cycle. For the random-read kind the victim bit is masked out of the comparison.

// File: rtl/cfi_pkg.sv
package cfi_pkg;

  typedef enum logic [2:0] {
    CF_STATE   = 3'd0,
    CF_DISTURB = 3'd1,
    CF_TRANS   = 3'd2,
    CF_IRD     = 3'd3,
    CF_RDEST   = 3'd4,
    CF_DRDEST  = 3'd5,
    CF_RRAND   = 3'd6,
    CF_NONE    = 3'd7
  } cf_kind_e;

  // Direction index: 0 above, 1 below, 2 left, 3 right.
  function automatic int nbr_dir(int sel, int use_rnd, int seed);
    if (use_rnd != 0) begin
      return (seed ^ (seed >> 3) ^ (seed >> 7)) & 3;
    end
    return sel & 3;
  endfunction

  // Neighbour word of a victim in a grid of rows x wpr, mirrored at the edges.
  function automatic int nbr_addr(int vic, int wpr, int rows, int dir);
    int r;
    int c;
    r = vic / wpr;
    c = vic % wpr;
    case (dir)
      0:       r = (r == 0) ? r + 1 : r - 1;
      1:       r = (r == rows - 1) ? r - 1 : r + 1;
      2:       c = (c == 0) ? c + 1 : c - 1;
      default: c = (c == wpr - 1) ? c - 1 : c + 1;
    endcase
    return r * wpr + c;
  endfunction

endpackage

// File: rtl/cfi_topology.sv
module cfi_topology #(
  parameter int ADDR_W        = 4,
  parameter int WORDS_PER_ROW = 4,
  parameter int VICTIM_ADDR   = 5,
  parameter int NBR_SEL       = 3,
  parameter int NBR_RANDOM    = 0,
  parameter int NBR_SEED      = 5
) (
  output logic [ADDR_W-1:0] vic_addr_o,
  output logic [ADDR_W-1:0] agg_addr_o
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int ROWS     = DEPTH / WORDS_PER_ROW;
  localparam int AGG_DIR  = cfi_pkg::nbr_dir(NBR_SEL, NBR_RANDOM, NBR_SEED);
  localparam int AGG_WORD = cfi_pkg::nbr_addr(VICTIM_ADDR, WORDS_PER_ROW, ROWS, AGG_DIR);

  assign vic_addr_o = ADDR_W'(VICTIM_ADDR);
  assign agg_addr_o = ADDR_W'(AGG_WORD);
endmodule

// File: rtl/cfi_lfsr.sv
module cfi_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] SEED = 16'hACE1,
  parameter logic [15:0] TAPS = 16'hB400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic bit_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = {1'b0, state_q[W-1:1]};
    if (state_q[0]) begin
      state_d = state_d ^ TAPS[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED[W-1:0];
    end else if (step_i) begin
      state_q <= state_d;
    end
  end

  assign bit_o = state_q[0];
endmodule

// File: rtl/cfi_rd_port.sv
module cfi_rd_port
  import cfi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              vic_hit_i,
  input  logic              armed_i,
  input  cf_kind_e          kind_i,
  input  logic              rnd_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rdata_d = word_i;
    if (vic_hit_i && armed_i) begin
      case (kind_i)
        CF_IRD, CF_RDEST: rdata_d[BIT] = ~word_i[BIT];
        CF_RRAND:         rdata_d[BIT] = rnd_i;
        default:          ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cfi_array.sv
module cfi_array
  import cfi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int BIT    = 2,
  parameter int NPORT  = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NPORT-1:0]                   en_i,
  input  logic [NPORT-1:0]                   we_i,
  input  logic [NPORT-1:0][ADDR_W-1:0]       addr_i,
  input  logic [NPORT-1:0][DATA_W-1:0]       data_i,
  input  logic [ADDR_W-1:0]                  vic_addr_i,
  input  logic [ADDR_W-1:0]                  agg_addr_i,
  input  logic                               fault_en_i,
  input  cf_kind_e                           kind_i,
  input  logic                               agg_level_i,
  input  logic                               vic_level_i,
  output logic [(1<<ADDR_W)-1:0][DATA_W-1:0] mem_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DEPTH-1:0][DATA_W-1:0] mem_d;
  logic [DEPTH-1:0]             word_we;
  logic armed;
  logic vic_wr;
  logic vic_rd;
  logic vic_wbit;
  logic agg_touch;

  // Access classification against victim and aggressor; port 0 evaluated last wins.
  always_comb begin
    armed     = fault_en_i && (mem_q[agg_addr_i][BIT] == agg_level_i);
    vic_wr    = 1'b0;
    vic_rd    = 1'b0;
    vic_wbit  = 1'b0;
    agg_touch = 1'b0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (en_i[p] && we_i[p] && (addr_i[p] == vic_addr_i)) begin
        vic_wr   = 1'b1;
        vic_wbit = data_i[p][BIT];
      end
      if (en_i[p] && !we_i[p] && (addr_i[p] == vic_addr_i)) begin
        vic_rd = 1'b1;
      end
      if (en_i[p] && (addr_i[p] == agg_addr_i)) begin
        agg_touch = 1'b1;
      end
    end
  end

  // Next array content: ideal writes, then the selected coupling effect.
  always_comb begin
    mem_d = mem_q;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (en_i[p] && we_i[p]) begin
        mem_d[addr_i[p]] = data_i[p];
      end
    end
    case (kind_i)
      CF_TRANS: begin
        if (armed && vic_wr && (mem_q[vic_addr_i][BIT] == vic_level_i) &&
            (vic_wbit != vic_level_i)) begin
          mem_d[vic_addr_i][BIT] = vic_level_i;
        end
      end
      CF_RDEST, CF_DRDEST: begin
        if (armed && vic_rd && !vic_wr) begin
          mem_d[vic_addr_i][BIT] = ~mem_q[vic_addr_i][BIT];
        end
      end
      CF_DISTURB: begin
        if (fault_en_i && agg_touch) begin
          mem_d[vic_addr_i][BIT] = ~mem_d[vic_addr_i][BIT];
        end
      end
      CF_STATE: begin
        if (fault_en_i && (mem_d[agg_addr_i][BIT] == agg_level_i) &&
            (mem_d[vic_addr_i][BIT] == vic_level_i)) begin
          mem_d[vic_addr_i][BIT] = ~vic_level_i;
        end
      end
      default: ;
    endcase
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_we
    assign word_we[w] = (mem_d[w] != mem_q[w]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        if (word_we[w]) begin
          mem_q[w] <= mem_d[w];
        end
      end
    end
  end

  assign mem_o = mem_q;
endmodule

// File: rtl/cfi_dpmem.sv
module cfi_dpmem
  import cfi_pkg::*;
#(
  parameter int          ADDR_W        = 4,
  parameter int          DATA_W        = 8,
  parameter int          WORDS_PER_ROW = 4,
  parameter int          VICTIM_ADDR   = 5,
  parameter int          VICTIM_BIT    = 2,
  parameter int          NBR_SEL       = 3,
  parameter int          NBR_RANDOM    = 0,
  parameter int          NBR_SEED      = 5,
  parameter logic [15:0] RND_SEED      = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  input  logic              fault_en,
  input  logic [2:0]        fault_kind,
  input  logic              agg_level,
  input  logic              vic_level
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NPORT = 2;

  logic [ADDR_W-1:0]              vic_addr;
  logic [ADDR_W-1:0]              agg_addr;
  logic [DEPTH-1:0][DATA_W-1:0]   mem_q;
  logic [NPORT-1:0]               p_en;
  logic [NPORT-1:0]               p_we;
  logic [NPORT-1:0][ADDR_W-1:0]   p_addr;
  logic [NPORT-1:0][DATA_W-1:0]   p_wdata;
  logic [NPORT-1:0][DATA_W-1:0]   p_rdata;
  logic [NPORT-1:0]               vic_rd;
  logic                           armed;
  logic                           rnd_bit;
  cf_kind_e                       kind;

  assign p_en    = {b_en, a_en};
  assign p_we    = {b_we, a_we};
  assign p_addr  = {b_addr, a_addr};
  assign p_wdata = {b_wdata, a_wdata};
  assign kind    = cf_kind_e'(fault_kind);

  cfi_topology #(
    .ADDR_W(ADDR_W), .WORDS_PER_ROW(WORDS_PER_ROW), .VICTIM_ADDR(VICTIM_ADDR),
    .NBR_SEL(NBR_SEL), .NBR_RANDOM(NBR_RANDOM), .NBR_SEED(NBR_SEED)
  ) u_topo (
    .vic_addr_o(vic_addr),
    .agg_addr_o(agg_addr)
  );

  cfi_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT(VICTIM_BIT), .NPORT(NPORT)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .en_i(p_en), .we_i(p_we), .addr_i(p_addr), .data_i(p_wdata),
    .vic_addr_i(vic_addr), .agg_addr_i(agg_addr),
    .fault_en_i(fault_en), .kind_i(kind),
    .agg_level_i(agg_level), .vic_level_i(vic_level),
    .mem_o(mem_q)
  );

  assign armed = fault_en && (mem_q[agg_addr][VICTIM_BIT] == agg_level);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign vic_rd[p] = p_en[p] && !p_we[p] && (p_addr[p] == vic_addr);

    cfi_rd_port #(.DATA_W(DATA_W), .BIT(VICTIM_BIT)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .rd_i(p_en[p] && !p_we[p]),
      .word_i(mem_q[p_addr[p]]),
      .vic_hit_i(p_addr[p] == vic_addr),
      .armed_i(armed),
      .kind_i(kind),
      .rnd_i(rnd_bit),
      .rdata_o(p_rdata[p])
    );
  end

  cfi_lfsr #(.W(16), .SEED(RND_SEED), .TAPS(16'hB400)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step_i(|vic_rd), .bit_o(rnd_bit)
  );

  assign a_rdata = p_rdata[0];
  assign b_rdata = p_rdata[1];
endmodule

// File: rtl/cfi_dpmem_chk.sv
module cfi_dpmem_chk
  import cfi_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int VICTIM_BIT = 2
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               a_en,
  input logic                               a_we,
  input logic [ADDR_W-1:0]                  a_addr,
  input logic [DATA_W-1:0]                  a_wdata,
  input logic [DATA_W-1:0]                  a_rdata,
  input logic                               b_en,
  input logic                               b_we,
  input logic [ADDR_W-1:0]                  b_addr,
  input logic                               fault_en,
  input logic [2:0]                         fault_kind,
  input logic                               agg_level,
  input logic                               vic_level,
  input logic [(1<<ADDR_W)-1:0][DATA_W-1:0] mem_q,
  input logic [ADDR_W-1:0]                  vic_addr,
  input logic [ADDR_W-1:0]                  agg_addr
);
  localparam int VB = VICTIM_BIT;

  logic armed_q;
  logic live;
  logic b_wr_vic;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign live     = fault_en && (mem_q[agg_addr][VB] == agg_level);
  assign b_wr_vic = b_en && b_we && (b_addr == vic_addr);

  p_ideal_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(a_en && !a_we && !fault_en) |-> a_rdata == $past(mem_q[a_addr]));

  p_write_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(a_en && a_we && (a_addr != vic_addr)) |-> mem_q[$past(a_addr)] == $past(a_wdata));

  p_state_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && fault_en && (fault_kind == CF_STATE) && $past(fault_en) &&
    ($past(fault_kind) == CF_STATE) && $stable(agg_level) && $stable(vic_level)
    |-> !((mem_q[agg_addr][VB] == agg_level) && (mem_q[vic_addr][VB] == vic_level)));

  p_disturb_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(fault_en && (fault_kind == CF_DISTURB) && a_en && (a_addr == agg_addr) &&
                     !(a_en && a_we && (a_addr == vic_addr)) && !b_wr_vic)
    |-> mem_q[vic_addr][VB] != $past(mem_q[vic_addr][VB]));

  p_trans_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(live && (fault_kind == CF_TRANS) && a_en && a_we && (a_addr == vic_addr) &&
                     !b_wr_vic && (mem_q[vic_addr][VB] == vic_level) && (a_wdata[VB] != vic_level))
    |-> mem_q[vic_addr][VB] == $past(vic_level));

  p_bad_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(live && (fault_kind == CF_IRD) && a_en && !a_we && (a_addr == vic_addr))
    |-> a_rdata[VB] != $past(mem_q[vic_addr][VB]));

  p_deceptive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(live && (fault_kind == CF_DRDEST) && a_en && !a_we && (a_addr == vic_addr) && !b_wr_vic)
    |-> (a_rdata[VB] == $past(mem_q[vic_addr][VB])) && (mem_q[vic_addr][VB] != $past(mem_q[vic_addr][VB])));
endmodule

bind cfi_dpmem cfi_dpmem_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VICTIM_BIT(VICTIM_BIT)
) chk_i (.*);

// File: tb/cfi_dpmem_tb_top.sv
`timescale 1ns/1ps
module cfi_dpmem_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int VB = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          a_en, a_we, b_en, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata;
  logic          fault_en, agg_level, vic_level;
  logic [2:0]    fault_kind;
  logic [DW-1:0] ra [2];
  logic [DW-1:0] rb [2];

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 1'b0;
  logic [DW-1:0] mdl [2][16];

  // Instance 0: victim 5 (row 1, col 1), right neighbour -> aggressor 6.
  cfi_dpmem dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(ra[0]),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rb[0]),
    .fault_en(fault_en), .fault_kind(fault_kind), .agg_level(agg_level), .vic_level(vic_level)
  );

  // Instance 1: victim 12 (row 3, col 0), random index (5^0^0)&3=1 below -> off grid -> above: 8.
  cfi_dpmem #(.VICTIM_ADDR(12), .NBR_SEL(0), .NBR_RANDOM(1), .NBR_SEED(5)) dut_edge_i (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(ra[1]),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rb[1]),
    .fault_en(fault_en), .fault_kind(fault_kind), .agg_level(agg_level), .vic_level(vic_level)
  );

  function automatic int vic_of(int i);
    return (i == 0) ? 5 : 12;
  endfunction

  function automatic int agg_of(int i);
    return (i == 0) ? 6 : 8;
  endfunction

  function automatic string tag_of(logic fe, logic [2:0] k);
    if (!fe) return "R5";
    case (k)
      3'd0: return "R6";
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd4: return "R10";
      3'd5: return "R11";
      3'd6: return "R12";
      default: return "R5";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // One clock cycle: drive after a falling edge, compare at the next falling edge.
  task automatic step(input logic ae, input logic aw, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                      input logic be, input logic bw, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
                      input string tag);
    logic [DW-1:0] ea [2];
    logic [DW-1:0] eb [2];
    logic [DW-1:0] ma [2];
    logic [DW-1:0] mb [2];
    logic [DW-1:0] nx [2][16];
    string t;
    t = (tag == "") ? tag_of(fault_en, fault_kind) : tag;
    a_en = ae; a_we = aw; a_addr = aa; a_wdata = ad;
    b_en = be; b_we = bw; b_addr = ba; b_wdata = bd;
    for (int i = 0; i < 2; i++) begin
      int  v;
      int  g;
      bit  arm, vw, vr, at, wb;
      v   = vic_of(i);
      g   = agg_of(i);
      arm = fault_en && (mdl[i][g][VB] == agg_level);
      ea[i] = mdl[i][aa]; ma[i] = '1;
      eb[i] = mdl[i][ba]; mb[i] = '1;
      if (arm && (fault_kind == 3'd3 || fault_kind == 3'd4)) begin
        if (aa == v) ea[i][VB] = ~ea[i][VB];
        if (ba == v) eb[i][VB] = ~eb[i][VB];
      end
      if (arm && fault_kind == 3'd6) begin
        if (aa == v) ma[i][VB] = 1'b0;
        if (ba == v) mb[i][VB] = 1'b0;
      end
      for (int w = 0; w < 16; w++) nx[i][w] = mdl[i][w];
      if (be && bw) nx[i][ba] = bd;
      if (ae && aw) nx[i][aa] = ad;
      vw = (ae && aw && aa == v) || (be && bw && ba == v);
      wb = (ae && aw && aa == v) ? ad[VB] : bd[VB];
      vr = (ae && !aw && aa == v) || (be && !bw && ba == v);
      at = (ae && aa == g) || (be && ba == g);
      case (fault_kind)
        3'd2: if (arm && vw && mdl[i][v][VB] == vic_level && wb != vic_level) nx[i][v][VB] = vic_level;
        3'd4, 3'd5: if (arm && vr && !vw) nx[i][v][VB] = ~mdl[i][v][VB];
        3'd1: if (fault_en && at) nx[i][v][VB] = ~nx[i][v][VB];
        3'd0: if (fault_en && nx[i][g][VB] == agg_level && nx[i][v][VB] == vic_level)
                nx[i][v][VB] = ~vic_level;
        default: ;
      endcase
    end
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      if (ae && !aw) check(((ra[i] ^ ea[i]) & ma[i]) == '0, t, $sformatf("inst%0d port A addr %0d", i, aa), ra[i], ea[i]);
      if (be && !bw) check(((rb[i] ^ eb[i]) & mb[i]) == '0, t, $sformatf("inst%0d port B addr %0d", i, ba), rb[i], eb[i]);
      for (int w = 0; w < 16; w++) mdl[i][w] = nx[i][w];
    end
  endtask

  function automatic logic [AW-1:0] pick_addr();
    case ($urandom_range(0, 7))
      0: return 4'd5;
      1: return 4'd6;
      2: return 4'd12;
      3: return 4'd8;
      default: return AW'($urandom_range(0, 15));
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_en = 0; a_we = 0; a_addr = 0; a_wdata = 0;
    b_en = 0; b_we = 0; b_addr = 0; b_wdata = 0;
    fault_en = 0; fault_kind = 3'd7; agg_level = 0; vic_level = 0;
    for (int i = 0; i < 2; i++) for (int w = 0; w < 16; w++) mdl[i][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of read outputs and of every word
    for (int i = 0; i < 2; i++) begin
      check(ra[i] == '0, "R1", "port A after reset", ra[i], '0);
      check(rb[i] == '0, "R1", "port B after reset", rb[i], '0);
    end
    for (int k = 0; k < 8; k++) step(1, 0, AW'(k), 0, 1, 0, AW'(k + 8), 0, "R1");

    // R2: read-before-write and readback
    step(1, 1, 4'd9, 8'h5A, 1, 0, 4'd9, 0, "R2");
    step(1, 0, 4'd9, 0, 0, 0, 0, 0, "R2");
    // R3: same-word write collision, port A stored
    step(1, 1, 4'd3, 8'h11, 1, 1, 4'd3, 8'h22, "R3");
    step(0, 0, 0, 0, 1, 0, 4'd3, 0, "R3");

    // R4: neighbour placement seen through disturb coupling in both instances
    fault_en = 1; fault_kind = 3'd1;
    step(1, 1, 4'd5, 8'h00, 1, 1, 4'd12, 8'h00, "R4");
    step(1, 0, 4'd6, 0, 1, 0, 4'd8, 0, "R4");
    step(1, 0, 4'd5, 0, 1, 0, 4'd12, 0, "R4");

    // R13: aggressor condition taken from stored content before the cycle's write
    fault_kind = 3'd3; agg_level = 1; vic_level = 0;
    step(1, 1, 4'd6, 8'h00, 1, 1, 4'd8, 8'h00, "R13");
    step(1, 1, 4'd6, 8'h04, 1, 0, 4'd5, 0, "R13");
    step(1, 1, 4'd8, 8'h04, 1, 0, 4'd5, 0, "R13");
    step(1, 0, 4'd12, 0, 1, 0, 4'd5, 0, "R13");

    // Sweep over enable, kind and both levels
    for (int fe = 0; fe < 2; fe++) begin
      for (int k = 0; k < 8; k++) begin
        for (int al = 0; al < 2; al++) begin
          for (int vl = 0; vl < 2; vl++) begin
            fault_en = fe[0]; fault_kind = k[2:0]; agg_level = al[0]; vic_level = vl[0];
            for (int n = 0; n < 40; n++) begin
              logic ae, aw, be, bw;
              ae = ($urandom_range(0, 3) != 0);
              be = ($urandom_range(0, 3) != 0);
              aw = $urandom_range(0, 1);
              bw = $urandom_range(0, 1);
              step(ae, aw, pick_addr(), DW'($urandom), be, bw, pick_addr(), DW'($urandom), "");
            end
            for (int w = 0; w < 16; w++) step(1, 0, AW'(w), 0, 1, 0, AW'(15 - w), 0, "");
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule